// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus (I2C) that holds 256 bytes of storage. It oversamples the bus clock and data lines with the system clock and recognises START and STOP conditions. It answers to one fixed 7-bit device address, and it keeps an 8-bit pointer that selects a byte of the array.

A master writes in one of two ways. It can send a word address followed by one data byte. It can also send a word address alone, which only moves the pointer. Reads begin at the pointer and can run over any number of bytes, for as long as the master acknowledges each one.

A completed data write is committed at the STOP that ends it. The commit starts a self-timed programming interval of fixed length. For that whole interval the block stays silent on the bus, even when the master sends its own address.

SDA is modelled as an open-drain output enable: a high on `sda_oe` pulls the line low.

Top module: `i2c_byte_store`

## Requirements
- R1: The device answers to the 7-bit address 1010000, sent MSB first and followed by a direction bit (0 = write, 1 = read). After a START and a matching address it pulls SDA low during the ninth SCL clock. After any other address it does not acknowledge, and it leaves SDA alone until the next START.
- R2: In a write, the first byte after the address is the word address. It is acknowledged and loaded into the pointer. The next byte is acknowledged as the data byte. Any further byte in the same transfer is not acknowledged.
- R3: The data byte is stored at the pointer when the STOP that ends the write is detected. `busy` rises on the next clock and stays high for exactly BUSY_CYCLES clocks.
- R4: While `busy` is high, no address is acknowledged, whether its direction bit selects a read or a write. SDA is never pulled low during that time.
- R5: A write that ends with STOP after the word address, with no data byte, moves the pointer only. It leaves the array unchanged and leaves `busy` low.
- R6: In a read, the byte at the pointer is shifted out MSB first, starting right after the address acknowledge. The pointer increases by one after each byte, wrapping from 0xFF to 0x00. When the master acknowledges, the next byte follows.
- R7: When the master does not acknowledge a read byte, the block releases SDA. It stays released until the next START.
- R8: A START or STOP at any point ends the current transfer and releases SDA. A START opens a new address phase. A write interrupted by a START before its STOP stores nothing.
- R9: The block starts pulling SDA low only while SCL is low.
- R10: After reset, SDA is released, `busy` is low, the pointer is 0x00 and every byte of the array is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pulls SDA low when high |
| busy | output | 1 | High during the programming interval |

## Verification
The bench looks for the following faults:
- A block that counts the busy interval wrong shows up as a `busy` pulse of the wrong length.
- A block that still acknowledges during programming is caught by address attempts made inside the interval.
- A sequential read is started from 0xFF. A pointer that does not wrap, or that advances at the wrong time, returns the wrong second byte or the wrong byte in the current-address read that follows.
- Once the master has not acknowledged, the bench clocks eight more bits. A block that keeps driving SDA turns the expected all-ones byte into something else.
- A write is cut short by a repeated START, and another ends after the word address alone. A block that commits on the wrong event either raises `busy` or changes the stored byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);
    localparam int PTR_W  = 8;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } ctl_state_e;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction
endpackage

// File: rtl/i2cs_line_sampler.sv
module i2cs_line_sampler
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt,
    output logic     scl_lvl
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_p, sda_p;
    logic scl_s, sda_s;

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    always_comb begin
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end

    assign scl_lvl = scl_s;
endmodule

// File: rtl/i2cs_busy_timer.sv
module i2cs_busy_timer #(
    parameter int BUSY_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (kick)
            remain <= CW'(BUSY_CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/i2cs_store.sv
module i2cs_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              commit,
    output logic              sda_oe
);
    ctl_state_e          state;
    logic [BIT_CW-1:0]   cnt;
    logic [BYTE_W-1:0]   rx_sh, tx_sh;
    logic                full, rw, mack, wr_pend;

    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    assign commit = evt.stop & wr_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            full    <= 1'b0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            wr_pend <= 1'b0;
            wr_data <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
        end else if (evt.start) begin
            state   <= ST_ADDR;
            cnt     <= '0;
            full    <= 1'b0;
            wr_pend <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (evt.stop) begin
            state   <= ST_IDLE;
            full    <= 1'b0;
            wr_pend <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (evt.scl_rise) begin
            case (state)
                ST_ADDR, ST_WORD, ST_DATA: begin
                    rx_sh <= {rx_sh[BYTE_W-2:0], evt.sda};
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST_BIT) full <= 1'b1;
                end
                ST_TX_ACK: mack <= ~evt.sda;
                default: ;
            endcase
        end else if (evt.scl_fall) begin
            case (state)
                ST_ADDR: if (full) begin
                    full <= 1'b0;
                    if (addr_hit(rx_sh, DEV_ADDR) && !busy) begin
                        sda_oe <= 1'b1;
                        rw     <= rx_sh[0];
                        state  <= ST_ADDR_ACK;
                    end else begin
                        state  <= ST_HOLD;
                    end
                end
                ST_ADDR_ACK: begin
                    cnt <= '0;
                    if (rw) begin
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        state  <= ST_TX;
                    end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WORD;
                    end
                end
                ST_WORD: if (full) begin
                    full   <= 1'b0;
                    ptr    <= rx_sh;
                    sda_oe <= 1'b1;
                    state  <= ST_WORD_ACK;
                end
                ST_WORD_ACK: begin
                    sda_oe <= 1'b0;
                    state  <= ST_DATA;
                end
                ST_DATA: if (full) begin
                    full    <= 1'b0;
                    wr_data <= rx_sh;
                    wr_pend <= 1'b1;
                    sda_oe  <= 1'b1;
                    state   <= ST_DATA_ACK;
                end
                ST_DATA_ACK: begin
                    sda_oe <= 1'b0;
                    state  <= ST_HOLD;
                end
                ST_TX: begin
                    if (cnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                        state  <= ST_TX_ACK;
                    end else begin
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_sh[BYTE_W-2];
                        cnt    <= cnt + 1'b1;
                    end
                end
                ST_TX_ACK: begin
                    if (mack) begin
                        cnt    <= '0;
                        tx_sh  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        state  <= ST_TX;
                    end else begin
                        state  <= ST_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1010000,
    parameter int         BUSY_CYCLES = 5000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic busy
);
    bus_evt_t          evt;
    logic              scl_lvl;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] wr_data, rd_data;
    logic              commit;

    i2cs_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .evt(evt), .scl_lvl(scl_lvl)
    );

    i2cs_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk(clk), .rst(rst), .evt(evt), .busy(busy), .rd_data(rd_data),
        .ptr(ptr), .wr_data(wr_data), .commit(commit), .sda_oe(sda_oe)
    );

    i2cs_store #(.ADDR_W(PTR_W), .DATA_W(BYTE_W)) u_store (
        .clk(clk), .rst(rst), .we(commit), .addr(ptr),
        .wdata(wr_data), .rdata(rd_data)
    );

    i2cs_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .kick(commit), .busy(busy)
    );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
    parameter int BUSY_CYCLES = 5000
) (
    input logic clk,
    input logic rst,
    input logic sda_oe,
    input logic busy,
    input logic scl_lvl,
    input logic ev_start,
    input logic ev_stop
);
    logic [31:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)       run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1;
        else           run_cnt <= '0;
    end

    p_no_ack_busy_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_lvl));

    p_release_evt_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_start || ev_stop) |=> !sda_oe);

    p_busy_after_stop_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ev_stop));

    p_busy_length_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_cnt == 32'(BUSY_CYCLES));
endmodule

bind i2c_byte_store i2cs_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .busy(busy), .scl_lvl(scl_lvl),
    .ev_start(evt.start), .ev_stop(evt.stop)
);

// File: tb/sim_i2c_byte_store.sv
`timescale 1ns/1ps
module sim_i2c_byte_store;
    localparam int BUSY = 2000;
    localparam int H    = 20;
    localparam int Q    = 10;
    localparam logic [7:0] DEV_W = 8'hA0;
    localparam logic [7:0] DEV_R = 8'hA1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, busy;
    wire  sda_ln = m_sda & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int r9_viol = 0;
    int busy_run = 0;
    int last_len = 0;
    int cyc = 0;
    logic oe_prev = 1'b0;

    always #5 clk = ~clk;

    i2c_byte_store #(.BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_ln),
        .sda_oe(sda_oe), .busy(busy)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        oe_prev <= sda_oe;
        if (!rst && sda_oe && !oe_prev && m_scl) r9_viol <= r9_viol + 1;
        if (busy) busy_run <= busy_run + 1;
        else if (busy_run != 0) begin
            last_len <= busy_run;
            busy_run <= 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tick(Q); m_sda = 1'b1;
        tick(Q); m_scl = 1'b1;
        tick(H); m_sda = 1'b0;
        tick(H); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_sda = 1'b0;
        tick(Q); m_scl = 1'b1;
        tick(H); m_sda = 1'b1;
        tick(H);
    endtask

    task automatic put_bit(input logic b);
        tick(Q); m_sda = b;
        tick(Q); m_scl = 1'b1;
        tick(H); m_scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        tick(Q); m_sda = 1'b1;
        tick(Q); m_scl = 1'b1;
        tick(Q); b = sda_ln;
        tick(Q); m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic wait_idle();
        while (busy) tick(1);
        tick(2);
    endtask

    task automatic write_byte(input logic [7:0] a, input logic [7:0] d);
        logic k;
        bus_start();
        send_byte(DEV_W, k); send_byte(a, k); send_byte(d, k);
        bus_stop();
        wait_idle();
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] d);
        logic k;
        bus_start();
        send_byte(DEV_W, k); send_byte(a, k);
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(d, 1'b0);
        bus_stop();
    endtask

    task automatic t_reset();
        logic k;
        logic [7:0] d;
        chk("R10 sda_oe after reset", sda_oe, 0);
        chk("R10 busy after reset", busy, 0);
        bus_start();
        send_byte(DEV_R, k);
        chk("R1 read address ack", k, 1);
        recv_byte(d, 1'b0);
        chk("R10 byte at pointer 0 after reset", d, 8'h00);
        bus_stop();
    endtask

    task automatic t_write_busy();
        logic k;
        logic [7:0] d;
        bus_start();
        send_byte(DEV_W, k); chk("R1 write address ack", k, 1);
        send_byte(8'h10, k); chk("R2 word address ack", k, 1);
        send_byte(8'hA5, k); chk("R2 data byte ack", k, 1);
        bus_stop();
        chk("R3 busy after stop", busy, 1);
        bus_start();
        send_byte(DEV_W, k); chk("R4 write address ignored while busy", k, 0);
        bus_stop();
        bus_start();
        send_byte(DEV_R, k); chk("R4 read address ignored while busy", k, 0);
        bus_stop();
        chk("R4 still inside programming interval", busy, 1);
        wait_idle();
        chk("R3 busy length", last_len, BUSY);
        read_at(8'h10, d);
        chk("R3 stored byte", d, 8'hA5);
    endtask

    task automatic t_extra_byte();
        logic k;
        logic [7:0] d;
        bus_start();
        send_byte(DEV_W, k); send_byte(8'h30, k); send_byte(8'h66, k);
        send_byte(8'h77, k);
        chk("R2 second data byte not acked", k, 0);
        bus_stop();
        wait_idle();
        read_at(8'h30, d);
        chk("R3 first data byte kept", d, 8'h66);
    endtask

    task automatic t_seq_wrap();
        logic k;
        logic [7:0] d;
        write_byte(8'hFF, 8'h3C);
        write_byte(8'h00, 8'h5A);
        write_byte(8'h01, 8'h96);
        bus_start();
        send_byte(DEV_W, k); send_byte(8'hFF, k);
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(d, 1'b1); chk("R6 first byte at 0xFF", d, 8'h3C);
        recv_byte(d, 1'b0); chk("R6 wrap to 0x00", d, 8'h5A);
        recv_byte(d, 1'b0); chk("R7 SDA released after no-ack", d, 8'hFF);
        bus_stop();
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(d, 1'b0); chk("R6 current read at 0x01", d, 8'h96);
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        logic k;
        bus_start();
        send_byte(8'hA2, k); chk("R1 other address not acked", k, 0);
        send_byte(8'h00, k); chk("R1 silent after mismatch", k, 0);
        bus_stop();
    endtask

    task automatic t_abort();
        logic k;
        logic [7:0] d;
        bus_start();
        send_byte(DEV_W, k); send_byte(8'h20, k); send_byte(8'h11, k);
        bus_start();
        send_byte(DEV_W, k); chk("R8 address after repeated start", k, 1);
        send_byte(8'h20, k);
        bus_stop();
        chk("R8 aborted write starts no programming", busy, 0);
        read_at(8'h20, d);
        chk("R8 aborted write stored nothing", d, 8'h00);
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte(DEV_W, k); chk("R8 start mid-address restarts", k, 1);
        bus_stop();
    endtask

    task automatic t_ptr_only();
        logic k;
        logic [7:0] d;
        bus_start();
        send_byte(DEV_W, k); send_byte(8'h10, k);
        bus_stop();
        chk("R5 pointer-only write leaves busy low", busy, 0);
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(d, 1'b0); chk("R5 pointer moved, data kept", d, 8'hA5);
        bus_stop();
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_write_busy();
        t_extra_byte();
        t_seq_wrap();
        t_wrong_addr();
        t_abort();
        t_ptr_only();
        chk("R9 SDA pulled only with SCL low", r9_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d expected below 150000 cycles", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule